// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller. It is organised as a set of banks, three by default, with thirty pins in each bank. For every pin it holds the following state:
- a direction bit;
- a bit that hands the pad to the GPIO function;
- an output data bit;
- a synchronised input sample.

Each pin can also raise an interrupt. Its interrupt settings are:
- a sensitivity type, either level or edge;
- a polarity;
- an enable;
- a sticky status bit.

Each bank drives one interrupt line. That line is the OR over the bank's pins of (pin is an input AND status is set AND interrupt is enabled).

Software reaches the block through a plain 32-bit register port. There are write strobes for each byte lane. Reads are combinational on the address. The port has no back-pressure: a write is accepted on every cycle in which `wr_en` is high, and `rdata` is valid in the same cycle as `addr`. Pins that must fire on both edges are handled in software, which flips the polarity after each event.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Address bits [7:4] select a register group and bits [3:2] select the bank. The groups are:
  - 0x0: direction
  - 0x2: polarity
  - 0x3: type
  - 0x4: enable
  - 0x5: status
  - 0x6: function enable
  - 0x7: input data
  - 0x8: output data

  Bank b's copy of a group sits at group offset + 4*b. A read of any other group, or of a bank index at or above the number of banks, returns zero.
- R2: After reset, every direction register reads 0x3FFFFFFF (all inputs). All other registers read zero, `pin_oe` is zero and every `irq` line is low.
- R3: Bits 31:30 of every register read as zero, and writing them has no effect.
- R4: A write changes only the byte lanes whose `wstrb` bit is set. `wstrb[k]` covers data bits 8k+7:8k.
- R5: A pin's `pin_oe` is high exactly when its direction bit is 0 (output) and its function-enable bit is 1. While `pin_oe` is high, `pin_out` shows the output data bit; otherwise `pin_out` is 0. Both follow the registers one cycle after the write.
- R6: Reading the input-data group returns the bank's pins after a two-stage synchroniser, that is, the pin values two clock edges earlier. Writes to this group are ignored.
- R7: A type bit of 0 selects level sensing. Polarity 1 means active-high and polarity 0 means active-low. A status bit is set on the third rising clock edge after the pin reaches its active level, and keeps being set while the level stays active.
- R8: A type bit of 1 selects edge sensing. Polarity 1 catches rising edges only and polarity 0 catches falling edges only. An edge is found by comparing two consecutive synchronised samples.
- R9: Writing 0 to a status bit clears it, and writing 1 leaves it as it is. When an event and a clear reach the same bit in the same cycle, the event wins, so an active level keeps its status bit set through a clear. An edge status bit stays clear until a new edge arrives.
- R10: `irq[b]` is the OR over bank b's pins of direction AND status AND enable. A pin set as an output therefore cannot raise its bank's interrupt, even with status and enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, accepted every cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane write enables |
| rdata | output | 32 | Combinational read data for `addr` |
| pin_in | input | NUM_BANKS*PINS (90) | Pad input levels, bank b at bits b*PINS upward |
| pin_out | output | NUM_BANKS*PINS (90) | Pad output data, zero where not driven |
| pin_oe | output | NUM_BANKS*PINS (90) | Pad output enables |
| irq | output | NUM_BANKS (3) | Interrupt line for each bank |

## Verification
The bench builds the block with its defaults: three banks of thirty pins. This value set leaves bank index 3 unmapped, which lets the bench check the zero-read path for a bank slot that does not exist. Thirty pins leave two dead bits at the top of each word and put the last pins in a partial top byte lane. Both cases are exercised through the strobe and upper-bit writes.

Random rounds change every bank's configuration, then move the pins from one random pattern to another. Expected status values are computed in the bench from the two patterns. Because the banks are independent, a bank-select or stride mistake shows up as a mismatch between banks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int GRP_W     = 4;
  localparam int BANK_W    = 2;
  localparam int MAX_BANKS = 1 << BANK_W;

  // register group codes, taken from addr[7:4]
  typedef enum logic [GRP_W-1:0] {
    GRP_DIR  = 4'h0,
    GRP_POL  = 4'h2,
    GRP_TYP  = 4'h3,
    GRP_IEN  = 4'h4,
    GRP_STS  = 4'h5,
    GRP_FEN  = 4'h6,
    GRP_DIN  = 4'h7,
    GRP_DOUT = 4'h8
  } reg_grp_e;

  typedef struct packed {
    logic [GRP_W-1:0]  grp;
    logic [BANK_W-1:0] bank;
    logic [1:0]        lane;
  } reg_addr_t;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int W = 30
) (
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic [W-1:0] evt
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lvl_hit, rise_hit, fall_hit;
    assign lvl_hit  = (cur[i] == pol[i]);
    assign rise_hit = cur[i] & ~prev[i];
    assign fall_hit = ~cur[i] & prev[i];
    assign evt[i]   = typ[i] ? (pol[i] ? rise_hit : fall_hit) : lvl_hit;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_sel,
  input  logic [GRP_W-1:0]     grp,
  input  logic [PINS-1:0]      wdata,
  input  logic [PINS-1:0]      wmask,
  output logic [PINS-1:0]      rdata,
  input  logic [PINS-1:0]      pin_in,
  output logic [PINS-1:0]      pin_out,
  output logic [PINS-1:0]      pin_oe,
  output logic                 irq
);

  logic [PINS-1:0] dir_q, pol_q, typ_q, ien_q, sts_q, fen_q, dout_q;
  logic [PINS-1:0] cur, prev, evt, clr;

  gpio_pin_sync #(.W(PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (pin_in),
    .q      (cur),
    .q_prev (prev)
  );

  gpio_evt_detect #(.W(PINS)) u_det (
    .typ  (typ_q),
    .pol  (pol_q),
    .cur  (cur),
    .prev (prev),
    .evt  (evt)
  );

  function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old);
    return (old & ~wmask) | (wdata & wmask);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      pol_q  <= '0;
      typ_q  <= '0;
      ien_q  <= '0;
      fen_q  <= '0;
      dout_q <= '0;
    end else if (wr_sel) begin
      case (grp)
        GRP_DIR:  dir_q  <= merge(dir_q);
        GRP_POL:  pol_q  <= merge(pol_q);
        GRP_TYP:  typ_q  <= merge(typ_q);
        GRP_IEN:  ien_q  <= merge(ien_q);
        GRP_FEN:  fen_q  <= merge(fen_q);
        GRP_DOUT: dout_q <= merge(dout_q);
        default: ;
      endcase
    end
  end

  // clear-by-zero, a fresh event takes precedence
  assign clr = (wr_sel && grp == GRP_STS) ? (wmask & ~wdata) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr) | evt;
  end

  always_comb begin
    case (grp)
      GRP_DIR:  rdata = dir_q;
      GRP_POL:  rdata = pol_q;
      GRP_TYP:  rdata = typ_q;
      GRP_IEN:  rdata = ien_q;
      GRP_STS:  rdata = sts_q;
      GRP_FEN:  rdata = fen_q;
      GRP_DIN:  rdata = cur;
      GRP_DOUT: rdata = dout_q;
      default:  rdata = '0;
    endcase
  end

  assign pin_oe  = ~dir_q & fen_q;
  assign pin_out = dout_q & pin_oe;
  assign irq     = |(dir_q & sts_q & ien_q);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [DATA_W/8-1:0]       wstrb,
  output logic [DATA_W-1:0]         rdata,
  input  logic [NUM_BANKS*PINS-1:0] pin_in,
  output logic [NUM_BANKS*PINS-1:0] pin_out,
  output logic [NUM_BANKS*PINS-1:0] pin_oe,
  output logic [NUM_BANKS-1:0]      irq
);

  localparam int PAD_W = DATA_W - PINS;

  reg_addr_t       dec;
  logic [PINS-1:0] wmask;
  logic [PINS-1:0] bank_rd [NUM_BANKS];
  logic [PINS-1:0] rd_sel;

  assign dec = reg_addr_t'(addr);

  always_comb begin
    for (int i = 0; i < PINS; i++) wmask[i] = wstrb[i/8];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_sel;
    assign wr_sel = wr_en && (dec.bank == BANK_W'(b));

    gpio_bank #(.PINS(PINS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_sel),
      .grp     (dec.grp),
      .wdata   (wdata[PINS-1:0]),
      .wmask   (wmask),
      .rdata   (bank_rd[b]),
      .pin_in  (pin_in[b*PINS +: PINS]),
      .pin_out (pin_out[b*PINS +: PINS]),
      .pin_oe  (pin_oe[b*PINS +: PINS]),
      .irq     (irq[b])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (dec.bank == BANK_W'(b)) rd_sel = bank_rd[b];
  end

  assign rdata = {{PAD_W{1'b0}}, rd_sel};

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 30
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         rdata,
  input logic [NUM_BANKS*PINS-1:0] pin_in,
  input logic [NUM_BANKS*PINS-1:0] pin_oe,
  input logic [NUM_BANKS-1:0]      irq
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  logic unmapped;
  assign unmapped = (addr[7:4] == 4'h1) || (addr[7:4] > 4'h8) ||
                    (32'(addr[3:2]) >= NUM_BANKS);

  // R2
  reset_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));

  // R1
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (rdata == '0));

  // R3
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:PINS] == '0);

  // R5
  oe_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(wr_en));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_din
    // R6
    din_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && addr[7:4] == 4'h7 && 32'(addr[3:2]) == b) |->
        (rdata[PINS-1:0] == $past(pin_in[b*PINS +: PINS], 2)));
  end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .PINS(PINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .addr   (addr),
  .rdata  (rdata),
  .pin_in (pin_in),
  .pin_oe (pin_oe),
  .irq    (irq)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

  localparam int NB = 3;
  localparam int NP = 30;
  localparam logic [31:0] FULL = 32'h3FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic [31:0] rdata;
  logic [NB*NP-1:0] pin_in = '0;
  logic [NB*NP-1:0] pin_out, pin_oe;
  logic [NB-1:0] irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NUM_BANKS(NB), .PINS(NP)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wstrb(wstrb), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [7:0] ra(input logic [3:0] grp, input int bank);
    return {grp, 2'(bank), 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_bank_pins(input int b, input logic [29:0] v);
    pin_in[b*NP +: NP] = v;
  endtask

  logic [29:0] m_dir [NB], m_pol [NB], m_typ [NB], m_ien [NB], m_fen [NB], m_dout [NB];
  logic [29:0] p0 [NB], p1 [NB];

  initial begin : main
    logic [31:0] v;
    logic [29:0] exp_sts;
    void'($urandom(32'h5EED_1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R2 reset state
    for (int b = 0; b < NB; b++) begin
      rd(ra(4'h0, b), v); chk("R2 dir reset", v, FULL);
      rd(ra(4'h2, b), v); chk("R2 pol reset", v, 0);
      rd(ra(4'h3, b), v); chk("R2 type reset", v, 0);
      rd(ra(4'h4, b), v); chk("R2 enable reset", v, 0);
      rd(ra(4'h6, b), v); chk("R2 fen reset", v, 0);
      rd(ra(4'h8, b), v); chk("R2 dout reset", v, 0);
    end
    chk("R2 irq reset", 32'(irq), 0);
    chk("R2 oe reset", 32'(pin_oe[29:0]), 0);

    // R1 map and unmapped
    wr(ra(4'h4, 1), 32'h0123_4567, 4'hF);
    rd(ra(4'h4, 1), v); chk("R1 bank1 enable", v, 32'h0123_4567);
    rd(ra(4'h4, 0), v); chk("R1 bank0 untouched", v, 0);
    rd(ra(4'h4, 2), v); chk("R1 bank2 untouched", v, 0);
    rd(8'h10, v); chk("R1 hole group", v, 0);
    rd(8'h0C, v); chk("R1 absent bank", v, 0);
    rd(8'h90, v); chk("R1 past map", v, 0);
    wr(ra(4'h4, 1), 0, 4'hF);

    // R3 upper bits
    wr(ra(4'h2, 2), 32'hFFFF_FFFF, 4'hF);
    rd(ra(4'h2, 2), v); chk("R3 upper bits", v, FULL);
    wr(ra(4'h2, 2), 0, 4'hF);

    // R4 byte strobes
    wr(ra(4'h8, 0), FULL, 4'b0101);
    rd(ra(4'h8, 0), v); chk("R4 lanes 0,2", v, 32'h00FF_00FF);
    wr(ra(4'h8, 0), FULL, 4'b1000);
    rd(ra(4'h8, 0), v); chk("R4 lane 3", v, 32'h3FFF_00FF);

    // R5 output drive
    chk("R5 input pin not driven", 32'(pin_out[29:0]), 0);
    wr(ra(4'h6, 0), FULL, 4'hF);
    wr(ra(4'h0, 0), 0, 4'hF);
    chk("R5 oe", 32'(pin_oe[29:0]), FULL);
    chk("R5 out", 32'(pin_out[29:0]), 32'h3FFF_00FF);
    wr(ra(4'h0, 0), FULL, 4'hF);
    chk("R5 oe off", 32'(pin_oe[29:0]), 0);
    chk("R5 out off", 32'(pin_out[29:0]), 0);
    wr(ra(4'h6, 0), 0, 4'hF);

    // R6 input read, write ignored
    set_bank_pins(1, 30'h1555_5555);
    tick(3);
    wr(ra(4'h7, 1), 0, 4'hF);
    rd(ra(4'h7, 1), v); chk("R6 din readonly", v, 32'h1555_5555);

    // R7 level latency on bank0 pin0
    wr(ra(4'h2, 0), 1, 4'hF);
    wr(ra(4'h5, 0), 0, 4'hF);
    wr(ra(4'h4, 0), 1, 4'hF);
    chk("R10 idle irq", 32'(irq[0]), 0);
    pin_in[0] = 1'b1;
    tick(2);
    rd(ra(4'h5, 0), v); chk("R7 not yet", 32'(v[0]), 0);
    tick(1);
    rd(ra(4'h5, 0), v); chk("R7 third edge", 32'(v[0]), 1);
    chk("R10 irq level", 32'(irq[0]), 1);
    // R9 clear loses to live level
    wr(ra(4'h5, 0), 0, 4'hF);
    rd(ra(4'h5, 0), v); chk("R9 level stays", v, FULL);
    pin_in[0] = 1'b0;
    tick(3);
    wr(ra(4'h5, 0), 32'h3FFF_FFFE, 4'hF);
    rd(ra(4'h5, 0), v); chk("R9 level cleared", 32'(v[0]), 0);
    chk("R10 irq drops", 32'(irq[0]), 0);

    // R8 edge on bank2 pin5
    wr(ra(4'h3, 2), FULL, 4'hF);
    wr(ra(4'h2, 2), 32'h20, 4'hF);
    wr(ra(4'h5, 2), 0, 4'hF);
    rd(ra(4'h5, 2), v); chk("R8 start clear", v, 0);
    pin_in[2*NP+5] = 1'b1; tick(4);
    rd(ra(4'h5, 2), v); chk("R8 rising caught", v, 32'h20);
    wr(ra(4'h5, 2), FULL, 4'hF);
    rd(ra(4'h5, 2), v); chk("R9 write one keeps", v, 32'h20);
    wr(ra(4'h5, 2), 0, 4'hF); tick(2);
    rd(ra(4'h5, 2), v); chk("R9 edge stays clear", v, 0);
    pin_in[2*NP+5] = 1'b0; tick(4);
    rd(ra(4'h5, 2), v); chk("R8 falling ignored", v, 0);
    wr(ra(4'h2, 2), 0, 4'hF);
    pin_in[2*NP+5] = 1'b1; tick(4);
    rd(ra(4'h5, 2), v); chk("R8 rising ignored", v, 0);
    pin_in[2*NP+5] = 1'b0; tick(4);
    rd(ra(4'h5, 2), v); chk("R8 falling caught", v, 32'h20);

    // R10 output pins masked
    wr(ra(4'h4, 2), 32'h20, 4'hF);
    chk("R10 input pin irq", 32'(irq[2]), 1);
    wr(ra(4'h0, 2), 32'h3FFF_FFDF, 4'hF);
    chk("R10 output pin masked", 32'(irq[2]), 0);
    wr(ra(4'h0, 2), FULL, 4'hF);
    chk("R10 back to input", 32'(irq[2]), 1);

    // random rounds
    for (int it = 0; it < 24; it++) begin
      for (int b = 0; b < NB; b++) begin
        m_dir[b] = 30'($urandom); m_pol[b] = 30'($urandom); m_typ[b] = 30'($urandom);
        m_ien[b] = 30'($urandom); m_fen[b] = 30'($urandom); m_dout[b] = 30'($urandom);
        wr(ra(4'h0, b), {2'b11, m_dir[b]}, 4'hF);
        wr(ra(4'h2, b), 32'(m_pol[b]), 4'hF);
        wr(ra(4'h3, b), 32'(m_typ[b]), 4'hF);
        wr(ra(4'h4, b), 32'(m_ien[b]), 4'hF);
        wr(ra(4'h6, b), 32'(m_fen[b]), 4'hF);
        wr(ra(4'h8, b), 32'(m_dout[b]), 4'hF);
        p0[b] = 30'($urandom); p1[b] = 30'($urandom);
        set_bank_pins(b, p0[b]);
      end
      tick(6);
      for (int b = 0; b < NB; b++) wr(ra(4'h5, b), 0, 4'hF);
      for (int b = 0; b < NB; b++) set_bank_pins(b, p1[b]);
      tick(6);
      for (int b = 0; b < NB; b++) begin
        exp_sts = (~m_typ[b] & ((p0[b] ~^ m_pol[b]) | (p1[b] ~^ m_pol[b]))) |
                  (m_typ[b] & ((m_pol[b] & ~p0[b] & p1[b]) | (~m_pol[b] & p0[b] & ~p1[b])));
        rd(ra(4'h5, b), v); chk("R7 R8 R9 random status", v, 32'(exp_sts));
        rd(ra(4'h7, b), v); chk("R6 random din", v, 32'(p1[b]));
        rd(ra(4'h0, b), v); chk("R3 random dir", v, 32'(m_dir[b]));
        chk("R10 random irq", 32'(irq[b]), 32'(|(m_dir[b] & exp_sts & m_ien[b])));
        chk("R5 random oe", 32'(pin_oe[b*NP +: NP]), 32'(~m_dir[b] & m_fen[b]));
        chk("R5 random out", 32'(pin_out[b*NP +: NP]), 32'(m_dout[b] & ~m_dir[b] & m_fen[b]));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule